// File: doc/BRIEF.md
# Two-Wire Bus Controller Interrupt Flag

This block owns the single interrupt-request flag of a two-wire serial bus controller. The bus waveform engine, the shift register and the address comparator sit elsewhere. They hand this block one-cycle event pulses: start and stop seen on the bus, the byte-end clock edges, an acknowledge sample with its value, an address received after lost arbitration, hits on the own addresses, general call and a software format-switch request. A mode select picks which of these events may raise the flag. The choices are bus master, bus slave, or a clocked serial mode with no addressing.

Software reads the flag through a status bit and drops it by a read-then-write-zero handshake. An access to the data register by the DMA-style transfer engine also drops it. The interrupt line is the flag gated by an enable bit. A small sequencer follows the bus transfer in the two addressed modes. Its states are `ST_IDLE` (no transfer), `ST_XFER` (transfer in progress) and `ST_HOLD` (byte finished, data not yet serviced). Its transitions are:
- `ST_IDLE`→`ST_XFER` on a start.
- `ST_XFER`→`ST_HOLD` on byte end.
- `ST_HOLD`→`ST_XFER` on a repeated start or a DMA data access.
- Any state→`ST_IDLE` on a stop, or whenever the clocked serial or reserved mode is selected.

While the sequencer is in `ST_HOLD`, the end-of-transfer set condition stays asserted.

Top module: `twi_irq_flag`

## Requirements
- R1: During and right after reset, `stat_flag` and `irq` are 0 and the sequencer is in `ST_IDLE`.
- R2: `irq` equals `stat_flag` AND `irq_en`. The flag records set events even while `irq_en` is 0.
- R3: The CPU clears the flag by reading it while it is 1 (`reg_rd`), then writing 0 (`reg_wr` with `reg_wbit`=0). A write of 0 with no prior read of 1 leaves the flag at 1.
- R4: Every CPU write discards a pending read-as-1 marker, so a write of 1 between the read and a write of 0 prevents clearing. A write of 1 never sets the flag. The flag never rises without a set event.
- R5: A pulse on `dma_acc` clears the flag.
- R6: Byte end is `ev_clk_rise9` when `wait_en`=0 and `ev_clk_fall8` when `wait_en`=1. The other edge is ignored.
- R7: With `mode_sel`=2'b00 (master), the flag sets on any of these:
  - `ev_start` while `start_issued`=1;
  - `ev_wait_ins` while `wait_en`=1;
  - byte end;
  - `ev_arb_addr`;
  - `ev_ack_in` with `ack_val`=1 while `ack_chk_en`=1.
  
  A start without `start_issued`, or an acknowledge of 1 with checking off, does not set it.
- R8: With `mode_sel`=2'b01 (slave), the flag sets on any of these:
  - any bit of `addr_hit`;
  - `ev_gen_call`;
  - an acknowledge of 1 with checking on;
  - `ev_stop`;
  - byte end.
  
  A start does not set it.
- R9: With `mode_sel`=2'b10 (clocked serial), the flag sets on byte end, on `ev_start` while `fmt_serial`=1, or on `ev_fmt_switch`. Address hits, stops and starts while `fmt_serial`=0 are ignored.
- R10: In master or slave mode, after a byte end in `ST_XFER`, the CPU cannot clear the flag until a stop or repeated start arrives. A DMA data access clears it at once.
- R11: If a set event and a clear request fall in the same cycle, the flag ends at 1.
- R12: A byte end in `ST_IDLE` sets the flag but does not enter `ST_HOLD`, so a CPU clear then works. A repeated start leaves `ST_HOLD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 master, 01 slave, 10 clocked serial, 11 reserved (no sets) |
| wait_en | input | 1 | Wait between data and acknowledge enabled |
| ack_chk_en | input | 1 | Acknowledge-value checking enabled |
| fmt_serial | input | 1 | Serial format selected (clocked serial mode) |
| irq_en | input | 1 | Interrupt enable |
| start_issued | input | 1 | Level: this controller has issued a start |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_clk_rise9 | input | 1 | Rising edge of 9th bus clock |
| ev_clk_fall8 | input | 1 | Falling edge of 8th bus clock |
| ev_wait_ins | input | 1 | Wait inserted before acknowledge |
| ev_arb_addr | input | 1 | Slave address received after arbitration loss |
| ev_ack_in | input | 1 | Acknowledge bit sampled |
| ack_val | input | 1 | Sampled acknowledge value |
| addr_hit | input | N_OWN | Own-address match, one bit per own address |
| ev_gen_call | input | 1 | General call address detected |
| ev_fmt_switch | input | 1 | Software format-switch bit written to 1 |
| reg_rd | input | 1 | CPU read of the status bit |
| reg_wr | input | 1 | CPU write of the status bit |
| reg_wbit | input | 1 | Value written to the status bit |
| dma_acc | input | 1 | DMA-style read or write of the data register |
| stat_flag | output | 1 | Flag value as read by the CPU |
| irq | output | 1 | Interrupt request |

## Verification
The flag is a register. An event, a clear write or a DMA pulse driven before a rising edge shows on `stat_flag` right after that edge, and `irq` follows `irq_en` with no delay. The sequencer state also changes on that edge, so a hold entered by a byte end already blocks a CPU clear whose write falls in the next cycle. The bench drives every input on the falling edge and holds pulses for one cycle. It samples on the next falling edge, half a period after the edge that acts on the pulse. It checks `irq` a nanosecond after changing `irq_en`.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;

    localparam int MODE_W  = 2;
    localparam int STATE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_MASTER = 2'b00,
        MODE_SLAVE  = 2'b01,
        MODE_CLKSER = 2'b10,
        MODE_RSVD   = 2'b11
    } bus_mode_e;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_XFER = 2'b01,
        ST_HOLD = 2'b10
    } xfer_state_e;

    // one-cycle bus event pulses plus the sampled acknowledge value
    typedef struct packed {
        logic start;
        logic stop;
        logic rise9;
        logic fall8;
        logic wait_ins;
        logic arb_addr;
        logic ack_in;
        logic ack_val;
        logic gen_call;
        logic fmt_switch;
    } twi_ev_t;

endpackage

// File: rtl/twi_irq_evsel.sv
module twi_irq_evsel
    import twi_irq_pkg::*;
#(
    parameter int N_OWN = 2
) (
    input  bus_mode_e          mode,
    input  logic               wait_en,
    input  logic               ack_chk_en,
    input  logic               fmt_serial,
    input  logic               start_issued,
    input  twi_ev_t            ev,
    input  logic [N_OWN-1:0]   addr_hit,
    input  logic               hold_active,
    input  logic               dma_acc,
    output logic               byte_end,
    output logic               set_any
);

    logic own_hit;
    logic ack_err;
    logic hold_set;
    logic set_master;
    logic set_slave;
    logic set_clkser;

    // byte-end edge depends on whether a wait precedes the acknowledge
    always_comb begin
        byte_end = wait_en ? ev.fall8 : ev.rise9;
    end

    always_comb begin
        own_hit  = |addr_hit;
        ack_err  = ev.ack_in & ev.ack_val & ack_chk_en;
        // pending data keeps the end-of-transfer cause alive until serviced
        hold_set = hold_active & ~dma_acc;
    end

    always_comb begin
        set_master = (ev.start & start_issued)
                   | (ev.wait_ins & wait_en)
                   | byte_end
                   | hold_set
                   | ev.arb_addr
                   | ack_err;
        set_slave  = own_hit
                   | ev.gen_call
                   | ack_err
                   | ev.stop
                   | byte_end
                   | hold_set;
        set_clkser = byte_end
                   | (ev.start & fmt_serial)
                   | ev.fmt_switch;
    end

    always_comb begin
        unique case (mode)
            MODE_MASTER: set_any = set_master;
            MODE_SLAVE:  set_any = set_slave;
            MODE_CLKSER: set_any = set_clkser;
            default:     set_any = 1'b0;
        endcase
    end

endmodule

// File: rtl/twi_irq_seq.sv
module twi_irq_seq
    import twi_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_i2c,
    input  logic        ev_start,
    input  logic        ev_stop,
    input  logic        byte_end,
    input  logic        dma_acc,
    output xfer_state_e state,
    output logic        hold_active
);

    xfer_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!mode_i2c || ev_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (ev_start)             state_nx = ST_XFER;
                ST_XFER: if (byte_end)             state_nx = ST_HOLD;
                ST_HOLD: if (ev_start || dma_acc)  state_nx = ST_XFER;
                default:                           state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        hold_active = (state == ST_HOLD);
    end

endmodule

// File: rtl/twi_irq_clr.sv
module twi_irq_clr (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic reg_rd,
    input  logic reg_wr,
    input  logic reg_wbit,
    input  logic dma_acc,
    output logic rd_mark,
    output logic clr_req
);

    // marker: the CPU has seen the flag at 1 since its last write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_mark <= 1'b0;
        end else if (reg_wr) begin
            rd_mark <= 1'b0;
        end else if (reg_rd && flag) begin
            rd_mark <= 1'b1;
        end
    end

    always_comb begin
        clr_req = dma_acc | (reg_wr & ~reg_wbit & rd_mark);
    end

endmodule

// File: rtl/twi_irq_flag.sv
module twi_irq_flag
    import twi_irq_pkg::*;
#(
    parameter int N_OWN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             wait_en,
    input  logic             ack_chk_en,
    input  logic             fmt_serial,
    input  logic             irq_en,
    input  logic             start_issued,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_clk_rise9,
    input  logic             ev_clk_fall8,
    input  logic             ev_wait_ins,
    input  logic             ev_arb_addr,
    input  logic             ev_ack_in,
    input  logic             ack_val,
    input  logic [N_OWN-1:0] addr_hit,
    input  logic             ev_gen_call,
    input  logic             ev_fmt_switch,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             reg_wbit,
    input  logic             dma_acc,
    output logic             stat_flag,
    output logic             irq
);

    bus_mode_e   mode;
    twi_ev_t     ev;
    xfer_state_e state;
    logic [STATE_W-1:0] state_bits;
    logic        mode_i2c;
    logic        byte_end;
    logic        set_any;
    logic        hold_active;
    logic        rd_mark;
    logic        clr_req;
    logic        flag_q;

    always_comb begin
        mode          = bus_mode_e'(mode_sel);
        mode_i2c      = (mode == MODE_MASTER) || (mode == MODE_SLAVE);
        ev.start      = ev_start;
        ev.stop       = ev_stop;
        ev.rise9      = ev_clk_rise9;
        ev.fall8      = ev_clk_fall8;
        ev.wait_ins   = ev_wait_ins;
        ev.arb_addr   = ev_arb_addr;
        ev.ack_in     = ev_ack_in;
        ev.ack_val    = ack_val;
        ev.gen_call   = ev_gen_call;
        ev.fmt_switch = ev_fmt_switch;
        state_bits    = state;
    end

    twi_irq_evsel #(
        .N_OWN (N_OWN)
    ) u_evsel (
        .mode         (mode),
        .wait_en      (wait_en),
        .ack_chk_en   (ack_chk_en),
        .fmt_serial   (fmt_serial),
        .start_issued (start_issued),
        .ev           (ev),
        .addr_hit     (addr_hit),
        .hold_active  (hold_active),
        .dma_acc      (dma_acc),
        .byte_end     (byte_end),
        .set_any      (set_any)
    );

    twi_irq_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i2c    (mode_i2c),
        .ev_start    (ev_start),
        .ev_stop     (ev_stop),
        .byte_end    (byte_end),
        .dma_acc     (dma_acc),
        .state       (state),
        .hold_active (hold_active)
    );

    twi_irq_clr u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag     (flag_q),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_wbit (reg_wbit),
        .dma_acc  (dma_acc),
        .rd_mark  (rd_mark),
        .clr_req  (clr_req)
    );

    // flag register: a set cause outranks any clear request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_any) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        stat_flag = flag_q;
        irq       = flag_q & irq_en;
    end

endmodule

// File: rtl/twi_irq_flag_chk.sv
module twi_irq_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flag,
    input logic       set_any,
    input logic       clr_req,
    input logic       rd_mark,
    input logic       reg_wr,
    input logic       dma_acc,
    input logic       hold_active,
    input logic       mode_i2c,
    input logic [1:0] state,
    input logic       ev_start,
    input logic       ev_stop
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!flag && state == 2'b00));

    a_r3_cpu_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_any) |=> !flag);

    a_r3_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && reg_wr && !rd_mark && !dma_acc) |=> flag);

    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        !set_any |=> !$rose(flag));

    a_r5_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_acc && !set_any) |=> !flag);

    a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && mode_i2c && !dma_acc) |=> flag);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> flag);

    a_r12_idle_to_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b00 && mode_i2c && ev_start && !ev_stop) |=> state == 2'b01);

endmodule

bind twi_irq_flag twi_irq_flag_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag        (flag_q),
    .set_any     (set_any),
    .clr_req     (clr_req),
    .rd_mark     (rd_mark),
    .reg_wr      (reg_wr),
    .dma_acc     (dma_acc),
    .hold_active (hold_active),
    .mode_i2c    (mode_i2c),
    .state       (state_bits),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop)
);

// File: tb/test_twi_irq_flag.sv
`timescale 1ns/1ps
module test_twi_irq_flag;

    localparam int N_OWN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic wait_en = 0, ack_chk_en = 0, fmt_serial = 0, irq_en = 0, start_issued = 0;
    logic ev_start = 0, ev_stop = 0, ev_clk_rise9 = 0, ev_clk_fall8 = 0, ev_wait_ins = 0;
    logic ev_arb_addr = 0, ev_ack_in = 0, ack_val = 0, ev_gen_call = 0, ev_fmt_switch = 0;
    logic [N_OWN-1:0] addr_hit = '0;
    logic reg_rd = 0, reg_wr = 0, reg_wbit = 0, dma_acc = 0;
    logic stat_flag, irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    twi_irq_flag #(.N_OWN(N_OWN)) i_twi_irq_flag (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wait_en(wait_en),
        .ack_chk_en(ack_chk_en), .fmt_serial(fmt_serial), .irq_en(irq_en),
        .start_issued(start_issued), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_clk_rise9(ev_clk_rise9), .ev_clk_fall8(ev_clk_fall8),
        .ev_wait_ins(ev_wait_ins), .ev_arb_addr(ev_arb_addr), .ev_ack_in(ev_ack_in),
        .ack_val(ack_val), .addr_hit(addr_hit), .ev_gen_call(ev_gen_call),
        .ev_fmt_switch(ev_fmt_switch), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wbit(reg_wbit), .dma_acc(dma_acc), .stat_flag(stat_flag), .irq(irq)
    );

    localparam int E_START = 0, E_STOP = 1, E_RISE9 = 2, E_FALL8 = 3, E_WAIT = 4,
                   E_ARB = 5, E_ACK = 6, E_HIT0 = 7, E_HIT1 = 8, E_GCALL = 9,
                   E_FSW = 10, E_DMA = 11;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic drive_ev(input int which, input logic v);
        case (which)
            E_START: ev_start      = v;
            E_STOP:  ev_stop       = v;
            E_RISE9: ev_clk_rise9  = v;
            E_FALL8: ev_clk_fall8  = v;
            E_WAIT:  ev_wait_ins   = v;
            E_ARB:   ev_arb_addr   = v;
            E_ACK:   ev_ack_in     = v;
            E_HIT0:  addr_hit[0]   = v;
            E_HIT1:  addr_hit[1]   = v;
            E_GCALL: ev_gen_call   = v;
            E_FSW:   ev_fmt_switch = v;
            E_DMA:   dma_acc       = v;
            default: ;
        endcase
    endtask

    // one-cycle pulse; returns on the falling edge after the acting rising edge
    task automatic pulse(input int which);
        drive_ev(which, 1'b1);
        @(negedge clk);
        drive_ev(which, 1'b0);
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 0;
        mode_sel = m; wait_en = 0; ack_chk_en = 0; fmt_serial = 0; start_issued = 0;
        reg_rd = 0; reg_wr = 0; reg_wbit = 0; ack_val = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic cpu_read;
        reg_rd = 1; @(negedge clk); reg_rd = 0;
    endtask

    task automatic cpu_write(input logic b);
        reg_wr = 1; reg_wbit = b; @(negedge clk); reg_wr = 0; reg_wbit = 0;
    endtask

    task automatic cpu_clear;
        cpu_read();
        cpu_write(1'b0);
    endtask

    task automatic t_reset;
        irq_en = 1;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1", "flag in reset", stat_flag, 1'b0);
        chk("R1", "irq in reset", irq, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "flag after reset", stat_flag, 1'b0);
        irq_en = 0;
    endtask

    task automatic t_enable_gate;
        do_reset(2'b10);
        irq_en = 0;
        pulse(E_FSW);
        chk("R2", "flag recorded with irq_en=0", stat_flag, 1'b1);
        chk("R2", "irq masked", irq, 1'b0);
        irq_en = 1; #1;
        chk("R2", "irq follows enable", irq, 1'b1);
        irq_en = 0; #1;
        chk("R2", "irq drops with enable", irq, 1'b0);
    endtask

    task automatic t_cpu_clear;
        do_reset(2'b10);
        pulse(E_FSW);
        cpu_write(1'b0);
        chk("R3", "write 0 without read", stat_flag, 1'b1);
        cpu_read();
        cpu_write(1'b1);
        chk("R4", "write 1 keeps flag", stat_flag, 1'b1);
        cpu_write(1'b0);
        chk("R4", "marker dropped by write 1", stat_flag, 1'b1);
        cpu_clear();
        chk("R3", "read then write 0", stat_flag, 1'b0);
        cpu_write(1'b1);
        chk("R4", "write 1 never sets", stat_flag, 1'b0);
    endtask

    task automatic t_dma_clear;
        do_reset(2'b10);
        pulse(E_FSW);
        pulse(E_DMA);
        chk("R5", "dma access clears", stat_flag, 1'b0);
    endtask

    task automatic t_byte_end;
        do_reset(2'b10);
        wait_en = 0;
        pulse(E_FALL8);
        chk("R6", "fall8 ignored, wait off", stat_flag, 1'b0);
        pulse(E_RISE9);
        chk("R6", "rise9 sets, wait off", stat_flag, 1'b1);
        cpu_clear();
        wait_en = 1;
        pulse(E_RISE9);
        chk("R6", "rise9 ignored, wait on", stat_flag, 1'b0);
        pulse(E_FALL8);
        chk("R6", "fall8 sets, wait on", stat_flag, 1'b1);
    endtask

    task automatic t_master;
        do_reset(2'b00);
        pulse(E_START);
        chk("R7", "start not issued", stat_flag, 1'b0);
        start_issued = 1;
        pulse(E_START);
        chk("R7", "start after issue", stat_flag, 1'b1);
        cpu_clear();
        start_issued = 0;
        pulse(E_WAIT);
        chk("R7", "wait insert, waits off", stat_flag, 1'b0);
        wait_en = 1;
        pulse(E_WAIT);
        chk("R7", "wait insert, waits on", stat_flag, 1'b1);
        cpu_clear();
        wait_en = 0;
        pulse(E_ARB);
        chk("R7", "address after arbitration loss", stat_flag, 1'b1);
        cpu_clear();
        ack_val = 1;
        pulse(E_ACK);
        chk("R7", "ack 1 with check off", stat_flag, 1'b0);
        ack_chk_en = 1; ack_val = 0;
        pulse(E_ACK);
        chk("R7", "ack 0 with check on", stat_flag, 1'b0);
        ack_val = 1;
        pulse(E_ACK);
        chk("R7", "ack 1 with check on", stat_flag, 1'b1);
        ack_val = 0; ack_chk_en = 0;
    endtask

    task automatic t_slave;
        do_reset(2'b01);
        start_issued = 1;
        pulse(E_START);
        chk("R8", "start ignored in slave", stat_flag, 1'b0);
        start_issued = 0;
        pulse(E_HIT0);
        chk("R8", "own address 0", stat_flag, 1'b1);
        cpu_clear();
        pulse(E_HIT1);
        chk("R8", "own address 1", stat_flag, 1'b1);
        cpu_clear();
        pulse(E_GCALL);
        chk("R8", "general call", stat_flag, 1'b1);
        cpu_clear();
        ack_chk_en = 1; ack_val = 1;
        pulse(E_ACK);
        chk("R8", "ack 1 with check on", stat_flag, 1'b1);
        cpu_clear();
        ack_chk_en = 0; ack_val = 0;
        pulse(E_STOP);
        chk("R8", "stop", stat_flag, 1'b1);
    endtask

    task automatic t_serial;
        do_reset(2'b10);
        pulse(E_START);
        chk("R9", "start without serial format", stat_flag, 1'b0);
        pulse(E_HIT0);
        chk("R9", "address hit ignored", stat_flag, 1'b0);
        pulse(E_STOP);
        chk("R9", "stop ignored", stat_flag, 1'b0);
        fmt_serial = 1;
        pulse(E_START);
        chk("R9", "start with serial format", stat_flag, 1'b1);
        cpu_clear();
        chk("R9", "cleared", stat_flag, 1'b0);
        pulse(E_FSW);
        chk("R9", "format switch", stat_flag, 1'b1);
        fmt_serial = 0;
        mode_sel = 2'b11;
        cpu_clear();
        pulse(E_FSW);
        chk("R9", "reserved mode sets nothing", stat_flag, 1'b0);
    endtask

    task automatic t_hold;
        do_reset(2'b00);
        pulse(E_START);
        pulse(E_RISE9);
        chk("R10", "byte end sets", stat_flag, 1'b1);
        cpu_clear();
        chk("R10", "cpu clear blocked in hold", stat_flag, 1'b1);
        pulse(E_STOP);
        cpu_clear();
        chk("R10", "cpu clear after stop", stat_flag, 1'b0);
        pulse(E_START);
        pulse(E_RISE9);
        pulse(E_DMA);
        chk("R10", "dma clears in hold", stat_flag, 1'b0);
        @(negedge clk);
        chk("R12", "hold left on dma", stat_flag, 1'b0);
        pulse(E_RISE9);
        pulse(E_START);
        cpu_clear();
        chk("R12", "repeated start leaves hold", stat_flag, 1'b0);
        do_reset(2'b01);
        pulse(E_RISE9);
        chk("R12", "byte end in idle sets", stat_flag, 1'b1);
        cpu_clear();
        chk("R12", "no hold from idle", stat_flag, 1'b0);
    endtask

    task automatic t_set_wins;
        do_reset(2'b10);
        pulse(E_FSW);
        cpu_read();
        ev_fmt_switch = 1;
        cpu_write(1'b0);
        ev_fmt_switch = 0;
        chk("R11", "set beats cpu clear", stat_flag, 1'b1);
        ev_fmt_switch = 1;
        pulse(E_DMA);
        ev_fmt_switch = 0;
        chk("R11", "set beats dma clear", stat_flag, 1'b1);
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_cpu_clear();
        t_dma_clear();
        t_byte_end();
        t_master();
        t_slave();
        t_serial();
        t_hold();
        t_set_wins();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule